// File: doc/BRIEF.md
# Internal Data Memory and Stack Front End

This block sits between the operand stage of an 8-bit microcontroller core and its on-chip data storage. Each cycle it takes one operand access and works out where it goes. In register mode a three-bit register number is placed inside the bank chosen by two bank bits. In direct mode the byte address is used as it is. In indirect mode a pointer held in register 0 or register 1 of the current bank supplies the address. The resolved access lands in a 256-byte RAM, in the stack pointer, or on a bus that leads to the special-function registers outside the block.

The same upper byte addresses (0x80 to 0xFF) lead to two different places. A direct access sends them to the special-function bus. An indirect access sends them to the upper half of the RAM. The block also holds the stack pointer, which can be read and written as the special-function byte 0x81. A separate push/pop port moves bytes between the core and a stack that grows upward inside the same RAM as the register banks. All reads are combinational within the cycle. All writes take effect at the rising clock edge.

Top module: `idata_access_unit`

## Requirements
- R1: A direct access (acc_mode 2'b01) to addresses 0x00–0x7F reads or writes RAM at that address, and neither sfr_rd nor sfr_wr is asserted.
- R2: A direct access to 0x80–0xFF, other than 0x81, goes to the SFR bus. A read asserts sfr_rd and returns sfr_rdata on acc_rdata. A write asserts sfr_wr with sfr_addr equal to the address and sfr_wdata equal to acc_wdata. The RAM is not touched.
- R3: An indirect access (acc_mode 2'b10) uses acc_addr[0] to pick register 0 or 1 of the active bank. The byte in that register is the RAM address, over the full 0x00–0xFF range. The access never reaches the SFR bus, so upper RAM is separate from the SFR space.
- R4: A register access (acc_mode 2'b00) uses n = acc_addr[2:0] and reaches RAM address 8*bank_sel + n.
- R5: After reset the stack pointer reads 0x07, and the first push writes RAM address 0x08.
- R6: A push first adds one to the stack pointer, then writes stk_wdata at the new stack pointer address.
- R7: During a pop cycle stk_rdata shows RAM at the current stack pointer. The stack pointer is one lower after the edge.
- R8: The stack pointer wraps modulo 256: a push from 0xFF gives 0x00, and a pop from 0x00 gives 0xFF.
- R9: A direct access to 0x81 reads or writes the stack pointer and asserts no SFR strobe.
- R10: If a direct write to 0x81 falls in the same cycle as a push or pop, the stack pointer takes the written value. The push still writes its byte at the old pointer plus one.
- R11: If push and pop are both asserted, only the push takes effect.
- R12: If an operand write and a push write target the same RAM byte in one cycle, the operand write is the one kept.
- R13: acc_mode 2'b11 is reserved. It writes nothing, asserts no SFR strobe and returns 0 on acc_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Operand access present this cycle |
| acc_mode | input | 2 | 00 register, 01 direct, 10 indirect, 11 reserved |
| acc_we | input | 1 | Operand access is a write |
| acc_addr | input | 8 | Direct address, register number, or pointer-register select |
| acc_wdata | input | 8 | Operand write data |
| acc_rdata | output | 8 | Operand read data |
| bank_sel | input | 2 | Active register bank |
| stk_push | input | 1 | Push strobe |
| stk_pop | input | 1 | Pop strobe |
| stk_wdata | input | 8 | Byte to push |
| stk_rdata | output | 8 | Byte at the stack pointer (popped byte) |
| sfr_addr | output | 8 | SFR bus address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data returned from outside |

## Verification
The assertions assume that bank_sel, acc_mode and the strobes are stable and known while rst_n is high. They also assume that sfr_rdata is valid in the same cycle as sfr_rd, because the bus has no wait states. The stimulus changes every input only just after a rising edge and returns to an idle state between scenarios. It never reads a RAM byte before writing it, so no check depends on uninitialised storage. SFR read data is driven by the bench to a known byte before each direct read of the upper range.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    AM_REG  = 2'b00,
    AM_DIR  = 2'b01,
    AM_IND  = 2'b10,
    AM_NONE = 2'b11
  } amode_e;

  localparam int IDATA_AW     = 8;
  localparam int IDATA_DW     = 8;
  localparam int IDATA_BANK_W = 2;
  localparam int IDATA_REG_W  = 3;
endpackage

// File: rtl/idata_addr_resolve.sv
module idata_addr_resolve
  import idata_pkg::*;
#(
  parameter int AW      = IDATA_AW,
  parameter int BANK_W  = IDATA_BANK_W,
  parameter int REG_W   = IDATA_REG_W,
  parameter logic [AW-1:0] SP_ADDR = 8'h81
) (
  input  amode_e              mode,
  input  logic [AW-1:0]       addr,
  input  logic [BANK_W-1:0]   bank,
  input  logic [AW-1:0]       ptr_val,
  output logic [AW-1:0]       ptr_slot,
  output logic [AW-1:0]       tgt_addr,
  output logic                hit_ram,
  output logic                hit_sfr,
  output logic                hit_sp
);
  localparam int SLOT_W = BANK_W + REG_W;

  // bank k, register n sits at 8*k + n (generalised to 2**REG_W registers)
  function automatic logic [AW-1:0] bank_slot(input logic [BANK_W-1:0] b,
                                              input logic [REG_W-1:0]  n);
    logic [SLOT_W-1:0] s;
    s = {b, n};
    return AW'(s);
  endfunction

  logic [REG_W-1:0] ptr_idx;
  assign ptr_idx  = {{(REG_W-1){1'b0}}, addr[0]};
  assign ptr_slot = bank_slot(bank, ptr_idx);

  always_comb begin
    tgt_addr = '0;
    hit_ram  = 1'b0;
    hit_sfr  = 1'b0;
    hit_sp   = 1'b0;
    unique case (mode)
      AM_REG: begin
        tgt_addr = bank_slot(bank, addr[REG_W-1:0]);
        hit_ram  = 1'b1;
      end
      AM_DIR: begin
        tgt_addr = addr;
        if (!addr[AW-1])          hit_ram = 1'b1;
        else if (addr == SP_ADDR) hit_sp  = 1'b1;
        else                      hit_sfr = 1'b1;
      end
      AM_IND: begin
        tgt_addr = ptr_val;
        hit_ram  = 1'b1;
      end
      default: begin
        tgt_addr = '0;
      end
    endcase
  end
endmodule

// File: rtl/idata_stack_ptr.sv
module idata_stack_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] push_slot,
  output logic          push_fire,
  output logic          pop_fire
);
  function automatic logic [AW-1:0] sp_up(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  function automatic logic [AW-1:0] sp_down(input logic [AW-1:0] v);
    return v - AW'(1);
  endfunction

  logic [AW-1:0] sp_nxt;

  assign push_fire = push;
  assign pop_fire  = pop && !push;
  assign push_slot = sp_up(sp);

  always_comb begin
    if (load)           sp_nxt = load_val;
    else if (push_fire) sp_nxt = push_slot;
    else if (pop_fire)  sp_nxt = sp_down(sp);
    else                sp_nxt = sp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= SP_RESET;
    else        sp <= sp_nxt;
  end

  a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load) |=> (sp == $past(sp) + AW'(1)));

  a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !load) |=> (sp == $past(sp) - AW'(1)));

  a_r8_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load && (sp == '1)) |=> (sp == '0));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sp == $past(load_val)));

  a_r11_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire && pop_fire));
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int NRD = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][DW-1:0]  rd_data,
  input  logic                    we_lo,
  input  logic [AW-1:0]           addr_lo,
  input  logic [DW-1:0]           data_lo,
  input  logic                    we_hi,
  input  logic [AW-1:0]           addr_hi,
  input  logic [DW-1:0]           data_hi
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = mem[rd_addr[g]];
    end
  endgenerate

  // later assignment wins: the high-priority port overrides on a shared byte
  always_ff @(posedge clk) begin
    if (we_lo) mem[addr_lo] <= data_lo;
    if (we_hi) mem[addr_hi] <= data_hi;
  end

  a_r12_hi_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && we_hi && (addr_lo == addr_hi)) |=> (mem[$past(addr_hi)] == $past(data_hi)));
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idata_pkg::*;
#(
  parameter int AW     = IDATA_AW,
  parameter int DW     = IDATA_DW,
  parameter int BANK_W = IDATA_BANK_W,
  parameter int REG_W  = IDATA_REG_W,
  parameter logic [AW-1:0] SP_ADDR  = 8'h81,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_mode,
  input  logic              acc_we,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              stk_push,
  input  logic              stk_pop,
  input  logic [DW-1:0]     stk_wdata,
  output logic [DW-1:0]     stk_rdata,
  output logic [AW-1:0]     sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata
);
  localparam int NRD    = 3;
  localparam int RD_PTR = 0;
  localparam int RD_TGT = 1;
  localparam int RD_STK = 2;

  amode_e        mode;
  logic [AW-1:0] ptr_slot, tgt_addr, sp, push_slot;
  logic          hit_ram, hit_sfr, hit_sp;
  logic          push_fire, pop_fire;
  logic          sp_load, ram_we_acc;
  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0][DW-1:0] rd_data;

  assign mode = amode_e'(acc_mode);

  idata_addr_resolve #(
    .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W), .SP_ADDR(SP_ADDR)
  ) u_resolve (
    .mode     (mode),
    .addr     (acc_addr),
    .bank     (bank_sel),
    .ptr_val  (rd_data[RD_PTR][AW-1:0]),
    .ptr_slot (ptr_slot),
    .tgt_addr (tgt_addr),
    .hit_ram  (hit_ram),
    .hit_sfr  (hit_sfr),
    .hit_sp   (hit_sp)
  );

  assign sp_load    = acc_valid && acc_we && hit_sp;
  assign ram_we_acc = acc_valid && acc_we && hit_ram;

  idata_stack_ptr #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .load      (sp_load),
    .load_val  (acc_wdata[AW-1:0]),
    .sp        (sp),
    .push_slot (push_slot),
    .push_fire (push_fire),
    .pop_fire  (pop_fire)
  );

  assign rd_addr[RD_PTR] = ptr_slot;
  assign rd_addr[RD_TGT] = tgt_addr;
  assign rd_addr[RD_STK] = sp;

  idata_ram #(.AW(AW), .DW(DW), .NRD(NRD)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .we_lo   (push_fire),
    .addr_lo (push_slot),
    .data_lo (stk_wdata),
    .we_hi   (ram_we_acc),
    .addr_hi (tgt_addr),
    .data_hi (acc_wdata)
  );

  assign stk_rdata = rd_data[RD_STK];

  assign sfr_rd    = acc_valid && !acc_we && hit_sfr;
  assign sfr_wr    = acc_valid &&  acc_we && hit_sfr;
  assign sfr_addr  = hit_sfr ? acc_addr : '0;
  assign sfr_wdata = sfr_wr ? acc_wdata : '0;

  always_comb begin
    if (!acc_valid)   acc_rdata = '0;
    else if (hit_ram) acc_rdata = rd_data[RD_TGT];
    else if (hit_sp)  acc_rdata = DW'(sp);
    else if (hit_sfr) acc_rdata = sfr_rdata;
    else              acc_rdata = '0;
  end

  a_r1_low_direct_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == AM_DIR && !acc_addr[AW-1]) |-> (!sfr_rd && !sfr_wr));

  a_r2_sfr_read_path: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rd |-> (acc_rdata == sfr_rdata));

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_rd, sfr_wr}));

  a_r3_indirect_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == AM_IND) |-> (!sfr_rd && !sfr_wr));

  a_r9_sp_slot_local: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == AM_DIR && acc_addr == SP_ADDR) |-> (!sfr_rd && !sfr_wr));

  a_r13_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == AM_NONE) |-> (!sfr_rd && !sfr_wr && acc_rdata == '0));

  a_r13_reserved_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == AM_NONE && !stk_push && !stk_pop) |=> $stable(sp));
endmodule

// File: tb/idata_access_unit_test.sv
`timescale 1ns/100ps
module idata_access_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid, acc_we, stk_push, stk_pop;
  logic [1:0] acc_mode, bank_sel;
  logic [7:0] acc_addr, acc_wdata, acc_rdata, stk_wdata, stk_rdata;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_rd, sfr_wr;

  int checks = 0;
  int errors = 0;

  logic [7:0] c_rdata, c_stk, c_saddr, c_swdata;
  logic       c_srd, c_swr;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  idata_access_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_mode(acc_mode),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .bank_sel(bank_sel), .stk_push(stk_push),
    .stk_pop(stk_pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  localparam logic [1:0] M_REG = 2'b00, M_DIR = 2'b01, M_IND = 2'b10, M_RSV = 2'b11;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_we = 0; acc_mode = M_DIR; acc_addr = 0; acc_wdata = 0;
    stk_push = 0; stk_pop = 0; stk_wdata = 0;
  endtask

  // one cycle: drive after an edge, capture outputs mid-cycle, pass the edge
  task automatic cyc(input logic val, input logic [1:0] md, input logic we,
                     input logic [7:0] a, input logic [7:0] wd,
                     input logic psh, input logic pp, input logic [7:0] swd);
    acc_valid = val; acc_mode = md; acc_we = we; acc_addr = a; acc_wdata = wd;
    stk_push = psh; stk_pop = pp; stk_wdata = swd;
    #1;
    c_rdata = acc_rdata; c_stk = stk_rdata; c_srd = sfr_rd; c_swr = sfr_wr;
    c_saddr = sfr_addr; c_swdata = sfr_wdata;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(input logic [1:0] md, input logic [7:0] a, input logic [7:0] d);
    cyc(1, md, 1, a, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] md, input logic [7:0] a, output logic [7:0] d);
    cyc(1, md, 0, a, 0, 0, 0, 0);
    d = c_rdata;
  endtask

  task automatic t_reset();
    rd(M_DIR, 8'h81, v);
    check(v == 8'h07, "R5 reset sp", v, 8'h07);
    check(!c_srd && !c_swr, "R9 sp read no strobe", {6'b0, c_srd, c_swr}, 8'h00);
  endtask

  task automatic t_first_pushes();
    cyc(0, M_DIR, 0, 0, 0, 1, 0, 8'hE1);
    rd(M_DIR, 8'h81, v);  check(v == 8'h08, "R5 sp after first push", v, 8'h08);
    rd(M_DIR, 8'h08, v);  check(v == 8'hE1, "R5 first push slot 0x08", v, 8'hE1);
    cyc(0, M_DIR, 0, 0, 0, 1, 0, 8'hE2);
    rd(M_DIR, 8'h09, v);  check(v == 8'hE2, "R6 second push slot", v, 8'hE2);
    cyc(0, M_DIR, 0, 0, 0, 0, 1, 0);
    check(c_stk == 8'hE2, "R7 pop data", c_stk, 8'hE2);
    rd(M_DIR, 8'h81, v);  check(v == 8'h08, "R7 sp after pop", v, 8'h08);
    cyc(0, M_DIR, 0, 0, 0, 0, 1, 0);
    check(c_stk == 8'hE1, "R7 second pop data", c_stk, 8'hE1);
    rd(M_DIR, 8'h81, v);  check(v == 8'h07, "R7 sp back to reset", v, 8'h07);
  endtask

  task automatic t_direct_low();
    wr(M_DIR, 8'h30, 8'hA5);
    check(!c_swr && !c_srd, "R1 low write no strobe", {6'b0, c_srd, c_swr}, 8'h00);
    rd(M_DIR, 8'h30, v);
    check(v == 8'hA5, "R1 low readback", v, 8'hA5);
    check(!c_srd, "R1 low read no strobe", {7'b0, c_srd}, 8'h00);
  endtask

  task automatic t_register();
    bank_sel = 2'd2;
    wr(M_REG, 8'h05, 8'h5C);
    bank_sel = 2'd0;
    rd(M_DIR, 8'h15, v);  check(v == 8'h5C, "R4 bank2 R5 at 0x15", v, 8'h5C);
    wr(M_REG, 8'h03, 8'h33);
    rd(M_DIR, 8'h03, v);  check(v == 8'h33, "R4 bank0 R3 at 0x03", v, 8'h33);
    bank_sel = 2'd3;
    wr(M_DIR, 8'h1F, 8'h9E);
    rd(M_REG, 8'h07, v);  check(v == 8'h9E, "R4 bank3 R7 read", v, 8'h9E);
    bank_sel = 2'd0;
  endtask

  task automatic t_sfr();
    wr(M_DIR, 8'h90, 8'h3E);
    check(c_swr && !c_srd, "R2 sfr write strobe", {6'b0, c_srd, c_swr}, 8'h01);
    check(c_saddr == 8'h90, "R2 sfr addr", c_saddr, 8'h90);
    check(c_swdata == 8'h3E, "R2 sfr wdata", c_swdata, 8'h3E);
    sfr_rdata = 8'h77;
    rd(M_DIR, 8'hC0, v);
    check(v == 8'h77 && c_srd, "R2 sfr read data", v, 8'h77);
    check(c_saddr == 8'hC0, "R2 sfr read addr", c_saddr, 8'hC0);
  endtask

  task automatic t_indirect();
    bank_sel = 2'd1;
    wr(M_DIR, 8'h08, 8'hC0);
    wr(M_DIR, 8'h09, 8'h40);
    wr(M_IND, 8'h00, 8'h9A);
    check(!c_swr && !c_srd, "R3 indirect upper write no strobe", {6'b0, c_srd, c_swr}, 8'h00);
    wr(M_DIR, 8'h40, 8'h11);
    rd(M_IND, 8'h01, v);  check(v == 8'h11, "R3 via R1", v, 8'h11);
    sfr_rdata = 8'h55;
    rd(M_IND, 8'h00, v);  check(v == 8'h9A, "R3 upper RAM not SFR", v, 8'h9A);
    check(!c_srd, "R3 indirect read no strobe", {7'b0, c_srd}, 8'h00);
    wr(M_DIR, 8'h08, 8'h90);
    wr(M_IND, 8'h00, 8'h21);
    rd(M_IND, 8'h00, v);  check(v == 8'h21, "R3 0x90 RAM distinct from SFR", v, 8'h21);
    bank_sel = 2'd0;
  endtask

  task automatic t_wrap();
    wr(M_DIR, 8'h81, 8'hFF);
    check(!c_swr, "R9 sp write no strobe", {7'b0, c_swr}, 8'h00);
    rd(M_DIR, 8'h81, v);  check(v == 8'hFF, "R9 sp written", v, 8'hFF);
    cyc(0, M_DIR, 0, 0, 0, 1, 0, 8'h5A);
    rd(M_DIR, 8'h81, v);  check(v == 8'h00, "R8 push wraps", v, 8'h00);
    rd(M_DIR, 8'h00, v);  check(v == 8'h5A, "R8 wrapped slot", v, 8'h5A);
    cyc(0, M_DIR, 0, 0, 0, 0, 1, 0);
    check(c_stk == 8'h5A, "R8 pop at 0x00 data", c_stk, 8'h5A);
    rd(M_DIR, 8'h81, v);  check(v == 8'hFF, "R8 pop wraps", v, 8'hFF);
  endtask

  task automatic t_sp_priority();
    wr(M_DIR, 8'h81, 8'h20);
    wr(M_DIR, 8'h21, 8'h00);
    cyc(1, M_DIR, 1, 8'h81, 8'h40, 1, 0, 8'h66);
    rd(M_DIR, 8'h81, v);  check(v == 8'h40, "R10 write beats push", v, 8'h40);
    rd(M_DIR, 8'h21, v);  check(v == 8'h66, "R10 push byte still stored", v, 8'h66);
    cyc(1, M_DIR, 1, 8'h81, 8'h50, 0, 1, 0);
    rd(M_DIR, 8'h81, v);  check(v == 8'h50, "R10 write beats pop", v, 8'h50);
  endtask

  task automatic t_both();
    wr(M_DIR, 8'h81, 8'h30);
    cyc(0, M_DIR, 0, 0, 0, 1, 1, 8'h71);
    rd(M_DIR, 8'h81, v);  check(v == 8'h31, "R11 push wins sp", v, 8'h31);
    rd(M_DIR, 8'h31, v);  check(v == 8'h71, "R11 push wins data", v, 8'h71);
  endtask

  task automatic t_collide();
    wr(M_DIR, 8'h81, 8'h40);
    cyc(1, M_DIR, 1, 8'h41, 8'hBB, 1, 0, 8'hAA);
    rd(M_DIR, 8'h41, v);  check(v == 8'hBB, "R12 operand write kept", v, 8'hBB);
    rd(M_DIR, 8'h81, v);  check(v == 8'h41, "R12 sp still advanced", v, 8'h41);
  endtask

  task automatic t_reserved();
    wr(M_DIR, 8'h10, 8'h12);
    cyc(1, M_RSV, 1, 8'h10, 8'hFF, 0, 0, 0);
    check(!c_swr && !c_srd, "R13 reserved no strobe", {6'b0, c_srd, c_swr}, 8'h00);
    cyc(1, M_RSV, 1, 8'h90, 8'hFF, 0, 0, 0);
    check(!c_swr, "R13 reserved upper no strobe", {7'b0, c_swr}, 8'h00);
    cyc(1, M_RSV, 0, 8'h10, 0, 0, 0, 0);
    check(c_rdata == 8'h00, "R13 reserved reads zero", c_rdata, 8'h00);
    rd(M_DIR, 8'h10, v);  check(v == 8'h12, "R13 RAM untouched", v, 8'h12);
  endtask

  initial begin
    idle();
    bank_sel = 0;
    sfr_rdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_first_pushes();
    t_direct_low();
    t_register();
    t_sfr();
    t_indirect();
    t_wrap();
    t_sp_priority();
    t_both();
    t_collide();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule